// File: doc/BRIEF.md
# NAND Page Buffer Address Mapper

This block turns a linear byte column within a NAND page into an address in the controller's internal buffer RAM. A page is seen as its main area followed by its spare area. The main area maps straight onto one linear buffer. The spare area is split into one chunk per 512-byte sector, and each chunk lands in its own small 64-byte buffer. Every buffer holds the same even number of valid bytes, and any bytes that do not divide evenly spill into the final buffer.

A client starts a transfer with a start column, a length, a geometry code and a spare-only flag. It then pulses a byte strobe once for each byte it moves. For the byte currently due, the block presents the RAM address, the buffer select, the byte offset inside that buffer and a main/spare flag. It also flags the last byte before a main/spare or spare-buffer boundary, so that the client can split its burst there. A request that would run past the end of the spare area is refused.

The geometry code and the spare-only flag are captured when a transfer starts. Changing either input during a transfer has no effect on it.

Top module: `nand_page_mapper`

## Requirements
- R1: The geometry code selects the page/spare byte pair: 0 is 512/16, 1 is 2048/64, 2 is 4096/128 and 3 is 4096/218. The valid bytes per spare buffer, V, equal the spare size divided by (page size / 512), rounded down to an even number: 16, 16, 16 and 26 respectively.
- R2: In normal mode a column below the page size is a main-area byte. For it, `addr_o` equals the column, `spare_o` is 0, `buf_sel_o` equals column/512 (3 bits) and `byte_off_o` equals column mod 512.
- R3: In normal mode a column at or above the page size addresses spare offset s = column − page size. In spare-only mode s equals the column. In both cases `spare_o` is 1.
- R4: For a spare offset s, the buffer index is min(floor(s/V), 7), `byte_off_o` equals s − index·V, `buf_sel_o` equals the index, and `addr_o` equals 0x1000 + index·0x40 + `byte_off_o`.
- R5: While `busy_o` is high, each strobe moves the column on by one. `busy_o` drops after `len_i` strobes. A strobe while idle has no effect.
- R6: `brk_o` is high on the last main-area byte (column = page − 1, normal mode only). It is also high on the last valid byte of each spare buffer, that is when `byte_off_o` = V − 1 with index below 7, or when s = spare size − 1.
- R7: `last_o` is high exactly on the final byte of the transfer.
- R8: A start whose column plus length exceeds the limit is refused. The limit is the spare size in spare-only mode and page plus spare size otherwise. A refused start ends any running transfer and sets `err_o`. `err_o` stays set until the next accepted start.
- R9: A start wins over a strobe in the same cycle. The new transfer begins at its own start column with no step applied. The geometry and mode captured at start govern the whole transfer.
- R10: After reset, `busy_o`, `err_o`, `brk_o` and `last_o` are low.
- R11: A start with zero length is accepted. It clears `err_o` and leaves `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| geom_i | input | 2 | Page/spare geometry code, captured at start |
| spare_only_i | input | 1 | Column counts from the start of the spare area, captured at start |
| start_i | input | 1 | Begin a transfer |
| start_col_i | input | 13 | First column of the transfer |
| len_i | input | 13 | Number of bytes to transfer |
| strobe_i | input | 1 | Current byte has been moved |
| busy_o | output | 1 | Transfer in progress; the address outputs are valid |
| err_o | output | 1 | Last start was refused for overrunning the spare area |
| addr_o | output | 13 | Buffer RAM address of the current byte |
| spare_o | output | 1 | Current byte lies in the spare area |
| buf_sel_o | output | 3 | Sector index (main) or spare buffer index (spare) |
| byte_off_o | output | 9 | Byte offset inside the selected sector or spare buffer |
| brk_o | output | 1 | Current byte is the last one before a region or spare-buffer boundary |
| last_o | output | 1 | Current byte is the final byte of the transfer |

## Verification
A new start and a byte strobe can arrive in the same cycle, and a running transfer then has to give way to the new one. The bench raises both inputs together in the middle of a transfer. It expects the next cycle to show the new start column with no step applied. The last byte of a transfer can also coincide with a buffer boundary, so that `brk_o` and `last_o` rise together. Transfers that end exactly on the last spare byte provoke this case, and the per-cycle model judges both flags on every cycle.

// File: rtl/nand_map_pkg.sv
package nand_map_pkg;

  typedef enum logic [1:0] {
    GEOM_P512_S16  = 2'd0,
    GEOM_P2K_S64   = 2'd1,
    GEOM_P4K_S128  = 2'd2,
    GEOM_P4K_S218  = 2'd3
  } geom_e;

  localparam int unsigned SECTOR_SH = 9;

  function automatic int unsigned page_bytes(geom_e g);
    case (g)
      GEOM_P512_S16: return 512;
      GEOM_P2K_S64:  return 2048;
      default:       return 4096;
    endcase
  endfunction

  function automatic int unsigned spare_bytes(geom_e g);
    case (g)
      GEOM_P512_S16: return 16;
      GEOM_P2K_S64:  return 64;
      GEOM_P4K_S128: return 128;
      default:       return 218;
    endcase
  endfunction

  // log2 of sectors per page
  function automatic int unsigned chunk_shift(geom_e g);
    case (g)
      GEOM_P512_S16: return 0;
      GEOM_P2K_S64:  return 2;
      default:       return 3;
    endcase
  endfunction

endpackage

// File: rtl/nand_geom_dec.sv
module nand_geom_dec
  import nand_map_pkg::*;
#(
  parameter int COL_W = 13
) (
  input  geom_e            geom_i,
  output logic [COL_W-1:0] page_o,
  output logic [COL_W-1:0] spare_o,
  output logic [COL_W-1:0] per_buf_o
);

  always_comb begin
    page_o    = COL_W'(page_bytes(geom_i));
    spare_o   = COL_W'(spare_bytes(geom_i));
    // chunks are a power of two: shift, then force even
    per_buf_o = (spare_o >> chunk_shift(geom_i)) & ~COL_W'(1);
  end

endmodule

// File: rtl/nand_spare_locate.sv
module nand_spare_locate #(
  parameter int OFF_W = 13,
  parameter int BUFS  = 8,
  localparam int IDX_W = $clog2(BUFS)
) (
  input  logic [OFF_W-1:0] s_i,
  input  logic [OFF_W-1:0] per_buf_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [OFF_W-1:0] off_o
);

  logic [BUFS-1:1] ge;

  // one threshold per buffer start; the count of those passed is the index,
  // and the clamp to the last buffer falls out of having only BUFS-1 of them
  for (genvar k = 1; k < BUFS; k++) begin : g_thr
    logic [OFF_W-1:0] thr;
    assign thr   = OFF_W'(k) * per_buf_i;
    assign ge[k] = (s_i >= thr);
  end

  always_comb begin
    idx_o = '0;
    for (int k = 1; k < BUFS; k++) begin
      if (ge[k]) idx_o = idx_o + 1'b1;
    end
  end

  assign off_o = s_i - OFF_W'(idx_o) * per_buf_i;

endmodule

// File: rtl/nand_xfer_ctrl.sv
module nand_xfer_ctrl #(
  parameter int COL_W = 13,
  parameter int LEN_W = 13,
  localparam int SUM_W = ((COL_W > LEN_W) ? COL_W : LEN_W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [COL_W-1:0] limit_i,
  input  logic             strobe_i,
  output logic [COL_W-1:0] col_o,
  output logic             busy_o,
  output logic             err_o,
  output logic             last_o,
  output logic             accept_o
);

  logic [COL_W-1:0] col_q;
  logic [LEN_W-1:0] rem_q;
  logic             busy_q, err_q;
  logic [SUM_W-1:0] end_col;
  logic             reject;

  assign end_col  = SUM_W'(start_col_i) + SUM_W'(len_i);
  assign reject   = end_col > SUM_W'(limit_i);
  assign accept_o = start_i & ~reject;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      rem_q  <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (start_i) begin
      col_q <= start_col_i;
      rem_q <= len_i;
      if (reject) begin
        busy_q <= 1'b0;
        err_q  <= 1'b1;
      end else begin
        busy_q <= (len_i != '0);
        err_q  <= 1'b0;
      end
    end else if (strobe_i && busy_q) begin
      col_q <= col_q + 1'b1;
      rem_q <= rem_q - 1'b1;
      if (rem_q == LEN_W'(1)) busy_q <= 1'b0;
    end
  end

  assign col_o  = col_q;
  assign busy_o = busy_q;
  assign err_o  = err_q;
  assign last_o = busy_q && (rem_q == LEN_W'(1));

  p_err_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);

  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && strobe_i && !start_i && !last_o |=> busy_o && (col_o == $past(col_o) + 1'b1));

  p_start_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && (len_i != '0) |=> busy_o && (col_o == $past(start_col_i)));

  p_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && strobe_i && !start_i |=> !busy_o);

endmodule

// File: rtl/nand_page_mapper.sv
module nand_page_mapper
  import nand_map_pkg::*;
#(
  parameter int              COL_W        = 13,
  parameter int              LEN_W        = 13,
  parameter int              ADDR_W       = 13,
  parameter int              SPARE_BUFS   = 8,
  parameter int              SPARE_STRIDE = 64,
  parameter logic [ADDR_W-1:0] SPARE_BASE = 13'h1000,
  localparam int IDX_W  = $clog2(SPARE_BUFS),
  localparam int STR_SH = $clog2(SPARE_STRIDE),
  localparam int BOFF_W = SECTOR_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        geom_i,
  input  logic              spare_only_i,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              strobe_i,
  output logic              busy_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              spare_o,
  output logic [IDX_W-1:0]  buf_sel_o,
  output logic [BOFF_W-1:0] byte_off_o,
  output logic              brk_o,
  output logic              last_o
);

  geom_e            geom_live, geom_q;
  logic             so_q;
  logic [COL_W-1:0] limit, col, page, spare_sz, per_buf, s_off, sp_off;
  logic [IDX_W-1:0] sp_idx;
  logic             accept, busy, in_spare, sp_brk;

  assign geom_live = geom_e'(geom_i);
  assign limit = spare_only_i ? COL_W'(spare_bytes(geom_live))
                              : COL_W'(page_bytes(geom_live) + spare_bytes(geom_live));

  nand_xfer_ctrl #(.COL_W(COL_W), .LEN_W(LEN_W)) i_ctrl (
    .clk_i, .rst_ni, .start_i, .start_col_i, .len_i,
    .limit_i (limit),
    .strobe_i,
    .col_o   (col),
    .busy_o  (busy),
    .err_o,
    .last_o,
    .accept_o(accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      geom_q <= GEOM_P512_S16;
      so_q   <= 1'b0;
    end else if (accept) begin
      geom_q <= geom_live;
      so_q   <= spare_only_i;
    end
  end

  nand_geom_dec #(.COL_W(COL_W)) i_geom (
    .geom_i   (geom_q),
    .page_o   (page),
    .spare_o  (spare_sz),
    .per_buf_o(per_buf)
  );

  assign in_spare = so_q || (col >= page);
  assign s_off    = so_q ? col : col - page;

  nand_spare_locate #(.OFF_W(COL_W), .BUFS(SPARE_BUFS)) i_loc (
    .s_i      (s_off),
    .per_buf_i(per_buf),
    .idx_o    (sp_idx),
    .off_o    (sp_off)
  );

  assign sp_brk = ((sp_off == per_buf - 1'b1) && (sp_idx != IDX_W'(SPARE_BUFS - 1)))
               || (s_off == spare_sz - 1'b1);

  always_comb begin
    if (in_spare) begin
      addr_o     = SPARE_BASE + (ADDR_W'(sp_idx) << STR_SH) + ADDR_W'(sp_off);
      buf_sel_o  = sp_idx;
      byte_off_o = BOFF_W'(sp_off);
    end else begin
      addr_o     = ADDR_W'(col);
      buf_sel_o  = col[SECTOR_SH +: IDX_W];
      byte_off_o = col[BOFF_W-1:0];
    end
  end

  assign spare_o = in_spare;
  assign busy_o  = busy;
  assign brk_o   = busy && (in_spare ? sp_brk : (col == page - 1'b1));

  p_spare_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && spare_o |-> (sp_off < COL_W'(SPARE_STRIDE)));

  p_main_below_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !spare_o |-> (addr_o < SPARE_BASE));

  p_last_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> busy_o);

  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !start_i |=> $stable(geom_q) && $stable(so_q));

endmodule

// File: tb/test_nand_page_mapper.sv
`timescale 1ns/1ps
module test_nand_page_mapper;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  geom_i = '0;
  logic        so_i = 1'b0, start_i = 1'b0, strobe_i = 1'b0;
  logic [12:0] col_i = '0, len_i = '0;
  logic        busy_o, err_o, spare_o, brk_o, last_o;
  logic [12:0] addr_o;
  logic [2:0]  buf_sel_o;
  logic [8:0]  byte_off_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nand_page_mapper i_nand_page_mapper (
    .clk_i(clk), .rst_ni(rst_n), .geom_i(geom_i), .spare_only_i(so_i),
    .start_i(start_i), .start_col_i(col_i), .len_i(len_i), .strobe_i(strobe_i),
    .busy_o, .err_o, .addr_o, .spare_o, .buf_sel_o, .byte_off_o, .brk_o, .last_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pg(int g); return (g == 0) ? 512 : (g == 1) ? 2048 : 4096; endfunction
  function automatic int sp(int g); return (g == 0) ? 16 : (g == 1) ? 64 : (g == 2) ? 128 : 218; endfunction

  // reference model
  int m_col, m_rem, m_busy, m_err, m_geom, m_so;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_col = 0; m_rem = 0; m_busy = 0; m_err = 0; m_geom = 0; m_so = 0;
    end else if (start_i) begin
      int lim;
      lim = so_i ? sp(geom_i) : pg(geom_i) + sp(geom_i);
      m_col = col_i; m_rem = len_i;
      if (int'(col_i) + int'(len_i) > lim) begin
        m_err = 1; m_busy = 0;
      end else begin
        m_err = 0; m_busy = (len_i != 0); m_geom = geom_i; m_so = so_i;
      end
    end else if (strobe_i && m_busy == 1) begin
      m_col++; m_rem--;
      if (m_rem == 0) m_busy = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R5 busy", busy_o, m_busy);
      chk("R8 err", err_o, m_err);
      if (m_busy == 1) begin
        int p, v, s, idx, off, a, bs, bo, br, isp;
        p = pg(m_geom);
        v = (sp(m_geom) / (p / 512)) & ~1;
        if (m_so == 1 || m_col >= p) begin
          s = (m_so == 1) ? m_col : m_col - p;
          idx = s / v; if (idx > 7) idx = 7;
          off = s - idx * v;
          a = 4096 + idx * 64 + off; bs = idx; bo = off; isp = 1;
          br = ((off == v - 1 && idx < 7) || s == sp(m_geom) - 1) ? 1 : 0;
          chk("R4 addr", addr_o, a);
          chk("R4 buf_sel", buf_sel_o, bs);
          chk("R4 byte_off", byte_off_o, bo);
        end else begin
          isp = 0; br = (m_col == p - 1) ? 1 : 0;
          chk("R2 addr", addr_o, m_col);
          chk("R2 buf_sel", buf_sel_o, (m_col / 512) % 8);
          chk("R2 byte_off", byte_off_o, m_col % 512);
        end
        chk("R3 spare", spare_o, isp);
        chk("R6 brk", brk_o, br);
        chk("R7 last", last_o, (m_rem == 1) ? 1 : 0);
      end
    end
  end

  task automatic kick(input int c, input int l, input int g, input bit so, input bit stb);
    start_i = 1'b1; col_i = 13'(c); len_i = 13'(l); geom_i = 2'(g); so_i = so; strobe_i = stb;
    @(negedge clk); #1;
    start_i = 1'b0; strobe_i = 1'b0;
  endtask

  int lfsr = 32'h1d3;
  task automatic pump(input bit gappy);
    while (busy_o) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
      strobe_i = gappy ? lfsr[0] : 1'b1;
      @(negedge clk); #1;
    end
    strobe_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 busy", busy_o, 0);
    chk("R10 err", err_o, 0);
    chk("R10 brk", brk_o, 0);
    chk("R10 last", last_o, 0);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;

    // main to spare crossing, then a chunk boundary; config change mid-transfer (R9)
    kick(2040, 20, 1, 0, 0);
    geom_i = 2'd0;
    repeat (8) begin strobe_i = 1'b1; @(negedge clk); #1; end
    strobe_i = 1'b0;
    chk("R9 latched geometry addr", addr_o, 13'h1000);
    pump(0);

    // R1: odd spare size, V=26, second buffer start
    kick(4096 + 26, 1, 3, 0, 0);
    chk("R1 addr", addr_o, 13'h1040);
    pump(0);

    // spare-only across clamp into last buffer, ending on last spare byte
    kick(170, 48, 3, 1, 0);
    pump(1);

    // small page, full run to end of spare
    kick(500, 28, 0, 0, 0);
    pump(1);

    // spare-only, whole spare of 4096/128 with gaps
    kick(0, 128, 2, 1, 0);
    pump(1);

    // R9: start beats strobe in the same cycle
    kick(100, 10, 1, 0, 0);
    repeat (3) begin strobe_i = 1'b1; @(negedge clk); #1; end
    kick(300, 5, 1, 0, 1);
    chk("R9 restart addr", addr_o, 300);
    chk("R9 restart busy", busy_o, 1);
    pump(0);

    // R8: overrun refused, then exact fit accepted
    kick(4096 + 200, 19, 3, 0, 0);
    chk("R8 err set", err_o, 1);
    chk("R8 busy low", busy_o, 0);
    // R5: strobes while idle do nothing
    repeat (3) begin strobe_i = 1'b1; @(negedge clk); #1; end
    strobe_i = 1'b0;
    chk("R5 idle busy", busy_o, 0);
    chk("R8 err held", err_o, 1);
    // R11: zero length clears error
    kick(0, 0, 0, 0, 0);
    chk("R11 err cleared", err_o, 0);
    chk("R11 busy low", busy_o, 0);
    kick(4096 + 200, 18, 3, 0, 0);
    pump(0);

    // refused start aborts a running transfer
    kick(0, 40, 2, 0, 0);
    kick(0, 200, 2, 1, 0);
    chk("R8 abort busy", busy_o, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

endmodule